// File: doc/BRIEF.md
# DMA Channel Register Bank

This block is the control and status register file of a multi-channel DMA layer with four transmit and two receive channels. Software reaches it through a simple synchronous port: a register number, a write strobe with write data, and a read strobe whose data appears on the next cycle. Each register keeps only its defined bits. Every status register is cleared bit by bit when a one is written to that bit. The configuration register can also act as a soft reset for the whole control and status set.

The DMA engine that fetches descriptors and moves data is outside this block. It reports errors, end-of-buffer events and descriptor errors through one-cycle set inputs. The bank then raises four level interrupt outputs from these status bits, each gated by its own enable bit. The bank also stores the per-channel table pointers and the receive buffer sizes for that engine.

Top module: `dma_regbank`

## Requirements
- R1: After reset, configuration (register 0x00) reads 0x0007C000. Every other register reads zero and all four interrupt outputs are low.
- R2: A write to configuration (0x00) stores the written word ANDed with 0x00FFC087.
- R3: A configuration write with bit 31 set first returns configuration, error status, interrupt enable, the channel-active set/reset registers and all end-of-buffer and descriptor-error status registers to their reset values, then stores the masked word. Table pointers and buffer sizes keep their contents.
- R4: Error status (0x01), TX end-of-buffer (0x06), TX descriptor error (0x07), RX end-of-buffer (0x0A) and RX descriptor error (0x0B) are write-one-to-clear: each written 1 clears that bit and each written 0 leaves it alone.
- R5: A one on a set input sets the matching status bit, and it wins over a clear in the same cycle. Error set bit k maps to error status bit k (bits 7:0). Transmit channel i maps to bit 31-i of the TX status registers. Receive channel i maps to bit 31-i of the RX status registers.
- R6: Interrupt enable (0x02) keeps bits 4:0 of a write.
- R7: TX channel-active set (0x04) and reset (0x05) keep bits 31:28. RX channel-active set (0x08) and reset (0x09) keep bits 31:30.
- R8: TX table pointers 0x10+i (i = 0..3) and RX table pointers 0x18+i (i = 0..1) store all 32 bits. RX buffer sizes 0x1C+i (i = 0..1) keep bits 7:0.
- R9: A read of any other register number returns zero, and a write to one changes nothing.
- R10: The interrupt outputs are gated by interrupt enable bits. irq[0] is high when any error status bit is set and enable bit 0 is 1. irq[1] does the same for TX end-of-buffer with enable bit 1. irq[2] does the same for RX end-of-buffer with enable bit 2. irq[3] is high when any TX or RX descriptor-error bit is set and enable bit 3 is 1.
- R11: Read data is registered. It shows the selected register one cycle after the read strobe and holds that value until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 5 | Register number |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| err_set | input | 8 | Error status set pulses |
| tx_eob_set | input | 4 | TX end-of-buffer set pulses, one per channel |
| tx_derr_set | input | 4 | TX descriptor-error set pulses |
| rx_eob_set | input | 2 | RX end-of-buffer set pulses |
| rx_derr_set | input | 2 | RX descriptor-error set pulses |
| irq | output | 4 | Interrupts: error, TX end-of-buffer, RX end-of-buffer, descriptor error |

## Verification
All 32 register numbers are written with all-ones, with two complementary checkerboards and with an irregular word, while the status registers are filled from the set inputs. A mask that is wrong in one bit, a decode that is shifted, and an unmapped number that aliases onto a real register each give a different readback. All-ones also hits the soft reset in configuration, and the complementary checkerboards tell apart a write-one-to-clear register from a register that stores the written value. Further tests put a set and a clear in the same cycle, apply a soft reset over filled pointers, and step the read strobe to catch a combinational or stale read path.

// File: rtl/dma_regbank_pkg.sv
package dma_regbank_pkg;
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 32;
  localparam int IEN_W   = 5;
  localparam int SIZE_W  = 8;

  localparam logic [DATA_W-1:0] CFG_MASK  = 32'h00FFC087;
  localparam logic [DATA_W-1:0] CFG_RESET = 32'h0007C000;

  localparam logic [ADDR_W-1:0] A_CFG    = 5'h00;
  localparam logic [ADDR_W-1:0] A_ERR    = 5'h01;
  localparam logic [ADDR_W-1:0] A_IEN    = 5'h02;
  localparam logic [ADDR_W-1:0] A_TXSET  = 5'h04;
  localparam logic [ADDR_W-1:0] A_TXRST  = 5'h05;
  localparam logic [ADDR_W-1:0] A_TXEOB  = 5'h06;
  localparam logic [ADDR_W-1:0] A_TXDERR = 5'h07;
  localparam logic [ADDR_W-1:0] A_RXSET  = 5'h08;
  localparam logic [ADDR_W-1:0] A_RXRST  = 5'h09;
  localparam logic [ADDR_W-1:0] A_RXEOB  = 5'h0A;
  localparam logic [ADDR_W-1:0] A_RXDERR = 5'h0B;
  localparam logic [ADDR_W-1:0] A_TXPTR  = 5'h10;
  localparam logic [ADDR_W-1:0] A_RXPTR  = 5'h18;
  localparam logic [ADDR_W-1:0] A_RXSIZE = 5'h1C;
endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dma_w1c_reg.sv
module dma_w1c_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_all,
  input  logic         wr_hit,
  input  logic [W-1:0] wbits,
  input  logic [W-1:0] set,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_en = clr_all | wr_hit | (|set);
    if (clr_all)     q_d = set;
    else if (wr_hit) q_d = set | (q & ~wbits);
    else             q_d = set | q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
  import dma_regbank_pkg::*;
#(
  parameter int NTX   = 4,
  parameter int NRX   = 2,
  parameter int ERR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [ERR_W-1:0]  err_set,
  input  logic [NTX-1:0]    tx_eob_set,
  input  logic [NTX-1:0]    tx_derr_set,
  input  logic [NRX-1:0]    rx_eob_set,
  input  logic [NRX-1:0]    rx_derr_set,
  output logic [3:0]        irq
);
  // channel i lives at bit (DATA_W-1-i) of the channel-mapped registers
  function automatic logic [NTX-1:0] tx_pick(input logic [DATA_W-1:0] v);
    for (int i = 0; i < NTX; i++) tx_pick[i] = v[DATA_W-1-i];
  endfunction
  function automatic logic [DATA_W-1:0] tx_put(input logic [NTX-1:0] v);
    tx_put = '0;
    for (int i = 0; i < NTX; i++) tx_put[DATA_W-1-i] = v[i];
  endfunction
  function automatic logic [NRX-1:0] rx_pick(input logic [DATA_W-1:0] v);
    for (int i = 0; i < NRX; i++) rx_pick[i] = v[DATA_W-1-i];
  endfunction
  function automatic logic [DATA_W-1:0] rx_put(input logic [NRX-1:0] v);
    rx_put = '0;
    for (int i = 0; i < NRX; i++) rx_put[DATA_W-1-i] = v[i];
  endfunction

  logic rst_ni;
  dma_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_ni));

  logic wr_cfg, soft_rst;
  assign wr_cfg   = wr_en && (addr == A_CFG);
  assign soft_rst = wr_cfg && wdata[DATA_W-1];

  // plain control registers
  logic [DATA_W-1:0] cfg_q, cfg_d;
  logic [IEN_W-1:0]  ien_q, ien_d;
  logic [NTX-1:0]    txset_q, txset_d, txrst_q, txrst_d;
  logic [NRX-1:0]    rxset_q, rxset_d, rxrst_q, rxrst_d;
  logic ien_en, txset_en, txrst_en, rxset_en, rxrst_en;

  always_comb begin
    cfg_d    = wdata & CFG_MASK;
    ien_en   = soft_rst | (wr_en && addr == A_IEN);
    txset_en = soft_rst | (wr_en && addr == A_TXSET);
    txrst_en = soft_rst | (wr_en && addr == A_TXRST);
    rxset_en = soft_rst | (wr_en && addr == A_RXSET);
    rxrst_en = soft_rst | (wr_en && addr == A_RXRST);
    ien_d    = soft_rst ? '0 : wdata[IEN_W-1:0];
    txset_d  = soft_rst ? '0 : tx_pick(wdata);
    txrst_d  = soft_rst ? '0 : tx_pick(wdata);
    rxset_d  = soft_rst ? '0 : rx_pick(wdata);
    rxrst_d  = soft_rst ? '0 : rx_pick(wdata);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= CFG_RESET;
      ien_q   <= '0;
      txset_q <= '0;
      txrst_q <= '0;
      rxset_q <= '0;
      rxrst_q <= '0;
    end else begin
      if (wr_cfg)   cfg_q   <= cfg_d;
      if (ien_en)   ien_q   <= ien_d;
      if (txset_en) txset_q <= txset_d;
      if (txrst_en) txrst_q <= txrst_d;
      if (rxset_en) rxset_q <= rxset_d;
      if (rxrst_en) rxrst_q <= rxrst_d;
    end
  end

  // write-one-to-clear status
  logic [ERR_W-1:0] err_q;
  logic [NTX-1:0]   txeob_q, txderr_q;
  logic [NRX-1:0]   rxeob_q, rxderr_q;

  dma_w1c_reg #(.W(ERR_W)) u_err (.clk(clk), .rst_n(rst_ni), .clr_all(soft_rst),
    .wr_hit(wr_en && addr == A_ERR), .wbits(wdata[ERR_W-1:0]), .set(err_set), .q(err_q));
  dma_w1c_reg #(.W(NTX)) u_txeob (.clk(clk), .rst_n(rst_ni), .clr_all(soft_rst),
    .wr_hit(wr_en && addr == A_TXEOB), .wbits(tx_pick(wdata)), .set(tx_eob_set), .q(txeob_q));
  dma_w1c_reg #(.W(NTX)) u_txderr (.clk(clk), .rst_n(rst_ni), .clr_all(soft_rst),
    .wr_hit(wr_en && addr == A_TXDERR), .wbits(tx_pick(wdata)), .set(tx_derr_set), .q(txderr_q));
  dma_w1c_reg #(.W(NRX)) u_rxeob (.clk(clk), .rst_n(rst_ni), .clr_all(soft_rst),
    .wr_hit(wr_en && addr == A_RXEOB), .wbits(rx_pick(wdata)), .set(rx_eob_set), .q(rxeob_q));
  dma_w1c_reg #(.W(NRX)) u_rxderr (.clk(clk), .rst_n(rst_ni), .clr_all(soft_rst),
    .wr_hit(wr_en && addr == A_RXDERR), .wbits(rx_pick(wdata)), .set(rx_derr_set), .q(rxderr_q));

  // channel pointers and sizes, untouched by the soft reset
  logic [DATA_W-1:0] txptr_q [NTX];
  logic [DATA_W-1:0] rxptr_q [NRX];
  logic [SIZE_W-1:0] rxsize_q [NRX];

  for (genvar t = 0; t < NTX; t++) begin : g_txptr
    logic hit;
    assign hit = wr_en && (addr == A_TXPTR + ADDR_W'(t));
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)  txptr_q[t] <= '0;
      else if (hit) txptr_q[t] <= wdata;
    end
  end

  for (genvar r = 0; r < NRX; r++) begin : g_rx
    logic ptr_hit, size_hit;
    assign ptr_hit  = wr_en && (addr == A_RXPTR + ADDR_W'(r));
    assign size_hit = wr_en && (addr == A_RXSIZE + ADDR_W'(r));
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        rxptr_q[r]  <= '0;
        rxsize_q[r] <= '0;
      end else begin
        if (ptr_hit)  rxptr_q[r]  <= wdata;
        if (size_hit) rxsize_q[r] <= wdata[SIZE_W-1:0];
      end
    end
  end

  // read path
  logic [DATA_W-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    case (addr)
      A_CFG:    rd_d = cfg_q;
      A_ERR:    rd_d[ERR_W-1:0] = err_q;
      A_IEN:    rd_d[IEN_W-1:0] = ien_q;
      A_TXSET:  rd_d = tx_put(txset_q);
      A_TXRST:  rd_d = tx_put(txrst_q);
      A_TXEOB:  rd_d = tx_put(txeob_q);
      A_TXDERR: rd_d = tx_put(txderr_q);
      A_RXSET:  rd_d = rx_put(rxset_q);
      A_RXRST:  rd_d = rx_put(rxrst_q);
      A_RXEOB:  rd_d = rx_put(rxeob_q);
      A_RXDERR: rd_d = rx_put(rxderr_q);
      default:  rd_d = '0;
    endcase
    for (int t = 0; t < NTX; t++)
      if (addr == A_TXPTR + ADDR_W'(t)) rd_d = txptr_q[t];
    for (int r = 0; r < NRX; r++) begin
      if (addr == A_RXPTR + ADDR_W'(r))  rd_d = rxptr_q[r];
      if (addr == A_RXSIZE + ADDR_W'(r)) rd_d = {{(DATA_W-SIZE_W){1'b0}}, rxsize_q[r]};
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    rdata <= '0;
    else if (rd_en) rdata <= rd_d;
  end

  assign irq[0] = (|err_q) & ien_q[0];
  assign irq[1] = (|txeob_q) & ien_q[1];
  assign irq[2] = (|rxeob_q) & ien_q[2];
  assign irq[3] = ((|txderr_q) | (|rxderr_q)) & ien_q[3];
endmodule

// File: rtl/dma_regbank_chk.sv
module dma_regbank_chk
  import dma_regbank_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [ERR_W-1:0]  err_set,
  input logic [ERR_W-1:0]  err_q,
  input logic [IEN_W-1:0]  ien_q,
  input logic [DATA_W-1:0] cfg_q,
  input logic [3:0]        irq
);
  p_cfg_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CFG) |=> (cfg_q == ($past(wdata) & CFG_MASK)));

  p_soft_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CFG && wdata[DATA_W-1]) |=> (ien_q == '0));

  p_w1c_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_ERR && err_set == '0) |=> ((err_q & $past(wdata[ERR_W-1:0])) == '0));

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_set) |=> ((err_q & $past(err_set)) == $past(err_set)));

  p_ien_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_IEN) |=> (rdata[DATA_W-1:IEN_W] == '0));

  p_size_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_RXSIZE) |=> (rdata[DATA_W-1:SIZE_W] == '0));

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 5'h1F) |=> (rdata == '0));

  p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq[0] |-> (ien_q[0] && (|err_q)));

  p_read_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en) |=> $stable(rdata));
endmodule

bind dma_regbank dma_regbank_chk #(.ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_ni), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .err_set(err_set), .err_q(err_q),
  .ien_q(ien_q), .cfg_q(cfg_q), .irq(irq)
);

// File: tb/tb_dma_regbank.sv
module tb_dma_regbank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [4:0]  addr;
  logic [31:0] wdata, rdata;
  logic [7:0]  err_set;
  logic [3:0]  tx_eob_set, tx_derr_set;
  logic [1:0]  rx_eob_set, rx_derr_set;
  logic [3:0]  irq;

  always #5 clk = ~clk;

  dma_regbank dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .err_set(err_set), .tx_eob_set(tx_eob_set),
    .tx_derr_set(tx_derr_set), .rx_eob_set(rx_eob_set), .rx_derr_set(rx_derr_set),
    .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] m [32];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] txp(input logic [3:0] v);
    return {v[0], v[1], v[2], v[3], 28'h0};
  endfunction
  function automatic logic [31:0] rxp(input logic [1:0] v);
    return {v[0], v[1], 30'h0};
  endfunction

  function automatic string req_of(input logic [4:0] a);
    case (a)
      5'h00: return "R2";
      5'h01, 5'h06, 5'h07, 5'h0A, 5'h0B: return "R4";
      5'h02: return "R6";
      5'h04, 5'h05, 5'h08, 5'h09: return "R7";
      5'h10, 5'h11, 5'h12, 5'h13, 5'h18, 5'h19, 5'h1C, 5'h1D: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [3:0] exp_irq();
    logic [3:0] e;
    e[0] = (m[1] != 0) && m[2][0];
    e[1] = (m[6] != 0) && m[2][1];
    e[2] = (m[10] != 0) && m[2][2];
    e[3] = ((m[7] != 0) || (m[11] != 0)) && m[2][3];
    return e;
  endfunction

  task automatic m_ctl_reset();
    m[0] = 32'h0007C000;
    for (int a = 1; a <= 11; a++) m[a] = 32'h0;
  endtask

  task automatic m_write(input logic [4:0] a, input logic [31:0] d);
    case (a)
      5'h00: begin if (d[31]) m_ctl_reset(); m[0] = d & 32'h00FFC087; end
      5'h02: m[2] = d & 32'h1F;
      5'h04, 5'h05: m[a] = d & 32'hF000_0000;
      5'h08, 5'h09: m[a] = d & 32'hC000_0000;
      5'h01, 5'h06, 5'h07, 5'h0A, 5'h0B: m[a] = m[a] & ~d;
      5'h10, 5'h11, 5'h12, 5'h13, 5'h18, 5'h19: m[a] = d;
      5'h1C, 5'h1D: m[a] = d & 32'hFF;
      default: ;
    endcase
  endtask

  // one bus cycle with optional write and side sets, then interrupt check
  task automatic op(input logic we, input logic [4:0] a, input logic [31:0] d,
                    input logic [7:0] es, input logic [3:0] te, input logic [3:0] td,
                    input logic [1:0] re, input logic [1:0] rd);
    @(negedge clk);
    wr_en = we; addr = a; wdata = d; err_set = es;
    tx_eob_set = te; tx_derr_set = td; rx_eob_set = re; rx_derr_set = rd;
    @(negedge clk);
    wr_en = 1'b0; err_set = '0; tx_eob_set = '0; tx_derr_set = '0;
    rx_eob_set = '0; rx_derr_set = '0;
    if (we) m_write(a, d);
    m[1]  = m[1] | {24'h0, es};
    m[6]  = m[6] | txp(te);
    m[7]  = m[7] | txp(td);
    m[10] = m[10] | rxp(re);
    m[11] = m[11] | rxp(rd);
    chk("R10", {28'h0, irq}, {28'h0, exp_irq()}, "irq");
  endtask

  task automatic rd_chk(input logic [4:0] a, input string req);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, rdata, m[a], $sformatf("read %02h", a));
  endtask

  task automatic fill_status();
    op(1'b0, 5'h03, 32'h0, 8'hFF, 4'hF, 4'hF, 2'h3, 2'h3);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hA5A5_5A5A;
    pats[2] = 32'h5A5A_A5A5; pats[3] = 32'h1234_5678;
    for (int a = 0; a < 32; a++) m[a] = 32'h0;
    m_ctl_reset();
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    err_set = '0; tx_eob_set = '0; tx_derr_set = '0; rx_eob_set = '0; rx_derr_set = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset contents
    chk("R1", {28'h0, irq}, 32'h0, "irq after reset");
    for (int a = 0; a < 32; a++) rd_chk(a[4:0], "R1");

    // sweep every register number with several patterns
    for (int p = 0; p < 4; p++) begin
      fill_status();
      for (int a = 0; a < 32; a++) begin
        op(1'b1, a[4:0], pats[p], 8'h0, 4'h0, 4'h0, 2'h0, 2'h0);
        rd_chk(a[4:0], req_of(a[4:0]));
      end
      for (int a = 0; a < 32; a++) rd_chk(a[4:0], req_of(a[4:0]));
    end

    // R10: enables with filled status, then clear groups one by one
    op(1'b1, 5'h02, 32'h0000_000F, 8'h0, 4'h0, 4'h0, 2'h0, 2'h0);
    fill_status();
    op(1'b1, 5'h01, 32'hFFFF_FFFF, 8'h0, 4'h0, 4'h0, 2'h0, 2'h0);
    op(1'b1, 5'h06, 32'hFFFF_FFFF, 8'h0, 4'h0, 4'h0, 2'h0, 2'h0);
    op(1'b1, 5'h07, 32'hFFFF_FFFF, 8'h0, 4'h0, 4'h0, 2'h0, 2'h0);
    op(1'b1, 5'h0B, 32'hFFFF_FFFF, 8'h0, 4'h0, 4'h0, 2'h0, 2'h0);
    op(1'b1, 5'h0A, 32'hFFFF_FFFF, 8'h0, 4'h0, 4'h0, 2'h0, 2'h0);
    op(1'b0, 5'h03, 32'h0, 8'h0, 4'h0, 4'h0, 2'h0, 2'h1);

    // R5: set and clear in the same cycle, set wins
    fill_status();
    op(1'b1, 5'h01, 32'hFFFF_FFFF, 8'h24, 4'h0, 4'h0, 2'h0, 2'h0);
    rd_chk(5'h01, "R5");
    op(1'b1, 5'h06, 32'hFFFF_FFFF, 8'h0, 4'h4, 4'h0, 2'h0, 2'h0);
    rd_chk(5'h06, "R5");
    op(1'b1, 5'h07, 32'hFFFF_FFFF, 8'h0, 4'h0, 4'h9, 2'h0, 2'h0);
    rd_chk(5'h07, "R5");
    op(1'b1, 5'h0A, 32'hFFFF_FFFF, 8'h0, 4'h0, 4'h0, 2'h2, 2'h0);
    rd_chk(5'h0A, "R5");
    op(1'b1, 5'h0B, 32'hFFFF_FFFF, 8'h0, 4'h0, 4'h0, 2'h0, 2'h1);
    rd_chk(5'h0B, "R5");

    // R3: soft reset keeps pointers and sizes
    for (int i = 0; i < 4; i++)
      op(1'b1, 5'h10 + i[4:0], 32'hC0DE_0000 + i, 8'h0, 4'h0, 4'h0, 2'h0, 2'h0);
    op(1'b1, 5'h19, 32'hBEEF_0019, 8'h0, 4'h0, 4'h0, 2'h0, 2'h0);
    op(1'b1, 5'h1D, 32'h0000_00A7, 8'h0, 4'h0, 4'h0, 2'h0, 2'h0);
    op(1'b1, 5'h02, 32'h0000_001F, 8'h0, 4'h0, 4'h0, 2'h0, 2'h0);
    op(1'b1, 5'h04, 32'hF000_0000, 8'h0, 4'h0, 4'h0, 2'h0, 2'h0);
    fill_status();
    op(1'b1, 5'h00, 32'h8000_4001, 8'h0, 4'h0, 4'h0, 2'h0, 2'h0);
    for (int a = 0; a < 32; a++) rd_chk(a[4:0], "R3");

    // R11: read latency and hold
    rd_chk(5'h1D, "R11");
    @(negedge clk);
    rd_en = 1'b1; addr = 5'h12;
    #2 chk("R11", rdata, m[5'h1D], "before edge");
    @(negedge clk);
    rd_en = 1'b0; addr = 5'h00;
    chk("R11", rdata, m[5'h12], "one cycle after strobe");
    @(negedge clk);
    chk("R11", rdata, m[5'h12], "held without strobe");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule